// File: doc/BRIEF.md
# Decimal Floating-Point Adder/Subtractor

This block adds or subtracts two unpacked decimal64 operands. Each operand arrives as a sign bit, a biased binary exponent and a sixteen-digit BCD significand, and the result leaves in the same unpacked form. A request input turns the operation into a subtraction by flipping the sign of the second operand. The block then decides whether the significands are really added or subtracted.

The operand with the larger exponent is routed to a large channel. The other significand is moved right by whole decimal digits in a single barrel-shift step, and the two are combined in a seventeen-digit BCD adder built from corrected digit cells. A subtraction that borrows is turned back into a magnitude by ten's complement, and the sign flips. A sum that reaches seventeen digits loses its lowest digit and raises the exponent by one. Digits moved off the low end by alignment or by that step are truncated.

The result is registered, so it appears one clock after the request, with a valid flag that follows the request flag. Special values, exception flags and rounding other than truncation are not handled.

Top module: `dfp_addsub`

## Requirements
- R1: The effective operation is a_sign XOR (b_sign XOR op_sub). A value of 0 adds the significands and 1 subtracts them; op_sub=1 therefore computes A minus B.
- R2: The operand with the strictly larger exponent is the large operand. When the exponents are equal, A is the large operand.
- R3: The small operand's significand is shifted right by exactly the exponent difference in decimal digits before it is combined, and the digits shifted out are discarded.
- R4: An exponent difference of 17 digits or more flushes the small significand to zero, so an addition returns the large operand unchanged.
- R5: BCD digit addition gives a correct decimal result: a binary digit sum above 9 is corrected by +6 and carries into the next digit (9 + 1 gives significand 0x10).
- R6: When an addition produces a seventeenth digit, the lowest digit is dropped and the result exponent is the larger exponent plus 1. Otherwise the result exponent equals the larger exponent.
- R7: With no borrow, the result sign is the sign of the large operand. For B this is b_sign XOR op_sub. An exact zero takes this sign.
- R8: When a subtraction borrows (large significand below the aligned small one), the result significand is the positive difference and the sign is the inverse of the large operand's sign.
- R9: The result and out_valid are registered one clock after in_valid. out_valid is 0 in cycles after an idle input. Synchronous reset clears out_valid, r_sign, r_exp and r_sig to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe for the operands on this cycle |
| op_sub | input | 1 | 1 selects A minus B, 0 selects A plus B |
| a_sign | input | 1 | Sign of A (1 means negative) |
| a_exp | input | EXP_W | Biased exponent of A |
| a_sig | input | 4*DIGITS | BCD significand of A, least significant digit in bits 3:0 |
| b_sign | input | 1 | Sign of B |
| b_exp | input | EXP_W | Biased exponent of B |
| b_sig | input | 4*DIGITS | BCD significand of B |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| r_sign | output | 1 | Result sign |
| r_exp | output | EXP_W | Result biased exponent |
| r_sig | output | 4*DIGITS | Result BCD significand |

## Verification
Every internal fault shows at the ports on the very next clock, because the block has one register stage and no other state. A wrong swap decision or shift count changes the low digits of r_sig, or the value of r_exp, for any pair with unequal exponents. A broken digit correction produces a non-decimal nibble or a wrong carry in r_sig. Faults in the borrow or seventeenth-digit paths show as a flipped r_sign, a complemented significand, or an exponent that is off by one on exactly those corner pairs. The scoreboard therefore drives each of those pairs explicitly.

// File: rtl/dfp_pkg.sv
package dfp_pkg;
  localparam int DIGIT_W = 4;

  function automatic logic [DIGIT_W-1:0] nines_digit(input logic [DIGIT_W-1:0] d);
    return 4'd9 - d;
  endfunction
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import dfp_pkg::*;
(
  input  logic [DIGIT_W-1:0] x,
  input  logic [DIGIT_W-1:0] y,
  input  logic               ci,
  output logic [DIGIT_W-1:0] s,
  output logic               co
);
  logic [DIGIT_W:0] raw;
  logic [DIGIT_W:0] fixed;

  always_comb begin
    raw   = {1'b0, x} + {1'b0, y} + {{DIGIT_W{1'b0}}, ci};
    co    = (raw > 5'd9);
    fixed = co ? raw + 5'd6 : raw;
    s     = fixed[DIGIT_W-1:0];
  end
endmodule

// File: rtl/bcd_adder.sv
module bcd_adder
  import dfp_pkg::*;
#(
  parameter int NDIG = 17
) (
  input  logic [DIGIT_W*NDIG-1:0] x,
  input  logic [DIGIT_W*NDIG-1:0] y,
  input  logic                    ci,
  output logic [DIGIT_W*NDIG-1:0] s,
  output logic                    co
);
  logic [NDIG:0] chain;
  assign chain[0] = ci;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    bcd_digit_add u_dig (
      .x  (x[DIGIT_W*g +: DIGIT_W]),
      .y  (y[DIGIT_W*g +: DIGIT_W]),
      .ci (chain[g]),
      .s  (s[DIGIT_W*g +: DIGIT_W]),
      .co (chain[g+1])
    );
  end

  assign co = chain[NDIG];
endmodule

// File: rtl/dfp_align.sv
module dfp_align
  import dfp_pkg::*;
#(
  parameter int DIGITS = 16,
  parameter int EXP_W  = 10
) (
  input  logic                        a_sign,
  input  logic [EXP_W-1:0]            a_exp,
  input  logic [DIGIT_W*DIGITS-1:0]   a_sig,
  input  logic                        b_sign,
  input  logic [EXP_W-1:0]            b_exp,
  input  logic [DIGIT_W*DIGITS-1:0]   b_sig,
  output logic                        l_sign,
  output logic [EXP_W-1:0]            l_exp,
  output logic [DIGIT_W*(DIGITS+1)-1:0] l_frame,
  output logic [DIGIT_W*(DIGITS+1)-1:0] s_frame
);
  localparam int FRAME   = DIGITS + 1;
  localparam int FRAME_W = DIGIT_W * FRAME;
  localparam int SH_W    = $clog2(FRAME);
  localparam logic [EXP_W-1:0] FRAME_E = EXP_W'(FRAME);

  logic                       swap;
  logic [EXP_W-1:0]           diff;
  logic [DIGIT_W*DIGITS-1:0]  small_sig;
  logic [FRAME_W-1:0]         stage [SH_W+1];

  always_comb begin
    swap      = (b_exp > a_exp);
    diff      = swap ? (b_exp - a_exp) : (a_exp - b_exp);
    l_sign    = swap ? b_sign : a_sign;
    l_exp     = swap ? b_exp  : a_exp;
    l_frame   = {{DIGIT_W{1'b0}}, (swap ? b_sig : a_sig)};
    small_sig = swap ? a_sig : b_sig;
  end

  assign stage[0] = {{DIGIT_W{1'b0}}, small_sig};
  for (genvar k = 0; k < SH_W; k++) begin : g_shift
    assign stage[k+1] = diff[k] ? (stage[k] >> (DIGIT_W << k)) : stage[k];
  end

  assign s_frame = (diff >= FRAME_E) ? '0 : stage[SH_W];
endmodule

// File: rtl/dfp_addsub.sv
module dfp_addsub
  import dfp_pkg::*;
#(
  parameter int DIGITS = 16,
  parameter int EXP_W  = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       op_sub,
  input  logic                       a_sign,
  input  logic [EXP_W-1:0]           a_exp,
  input  logic [DIGIT_W*DIGITS-1:0]  a_sig,
  input  logic                       b_sign,
  input  logic [EXP_W-1:0]           b_exp,
  input  logic [DIGIT_W*DIGITS-1:0]  b_sig,
  output logic                       out_valid,
  output logic                       r_sign,
  output logic [EXP_W-1:0]           r_exp,
  output logic [DIGIT_W*DIGITS-1:0]  r_sig
);
  localparam int FRAME   = DIGITS + 1;
  localparam int FRAME_W = DIGIT_W * FRAME;
  localparam int SIG_W   = DIGIT_W * DIGITS;
  localparam logic [EXP_W-1:0] FRAME_E = EXP_W'(FRAME);

  function automatic logic [FRAME_W-1:0] nines_frame(input logic [FRAME_W-1:0] v);
    logic [FRAME_W-1:0] o;
    for (int i = 0; i < FRAME; i++) o[DIGIT_W*i +: DIGIT_W] = nines_digit(v[DIGIT_W*i +: DIGIT_W]);
    return o;
  endfunction

  // effective operation (R1)
  logic b_sign_eff, eff_sub;
  assign b_sign_eff = b_sign ^ op_sub;
  assign eff_sub    = a_sign ^ b_sign_eff;

  logic               l_sign;
  logic [EXP_W-1:0]   l_exp;
  logic [FRAME_W-1:0] l_frame, s_frame;

  dfp_align #(.DIGITS(DIGITS), .EXP_W(EXP_W)) u_align (
    .a_sign (a_sign), .a_exp (a_exp), .a_sig (a_sig),
    .b_sign (b_sign_eff), .b_exp (b_exp), .b_sig (b_sig),
    .l_sign (l_sign), .l_exp (l_exp), .l_frame (l_frame), .s_frame (s_frame)
  );

  // main add or nine's-complement subtract
  logic [FRAME_W-1:0] addend, raw, neg, mag;
  logic               c_main, c_neg, borrow, top_digit;

  assign addend = eff_sub ? nines_frame(s_frame) : s_frame;

  bcd_adder #(.NDIG(FRAME)) u_main (
    .x (l_frame), .y (addend), .ci (eff_sub), .s (raw), .co (c_main)
  );

  // ten's complement path for a borrowing subtraction
  bcd_adder #(.NDIG(FRAME)) u_recomp (
    .x (nines_frame(raw)), .y ('0), .ci (1'b1), .s (neg), .co (c_neg)
  );

  logic [SIG_W-1:0] res_sig;
  logic [EXP_W-1:0] res_exp;
  logic             res_sign;

  always_comb begin
    borrow    = eff_sub & ~c_main;
    mag       = borrow ? neg : raw;
    top_digit = |mag[FRAME_W-1 -: DIGIT_W];
    res_sig   = top_digit ? mag[FRAME_W-1:DIGIT_W] : mag[SIG_W-1:0];
    res_exp   = l_exp + {{(EXP_W-1){1'b0}}, top_digit};
    res_sign  = l_sign ^ borrow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      r_sign    <= 1'b0;
      r_exp     <= '0;
      r_sig     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        r_sign <= res_sign;
        r_exp  <= res_exp;
        r_sig  <= res_sig;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_large_exp_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (l_exp >= a_exp && l_exp >= b_exp));

  assert_flush_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ((a_exp > b_exp ? a_exp - b_exp : b_exp - a_exp) >= FRAME_E)) |-> (s_frame == '0));

  assert_sub_narrow_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && eff_sub) |-> (mag[FRAME_W-1 -: DIGIT_W] == '0));

  assert_recomp_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && borrow) |-> !c_neg);

  assert_exp_step_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((r_exp - $past(l_exp)) <= EXP_W'(1)));
endmodule

// File: tb/dfp_addsub_test.sv
module dfp_addsub_test;
  localparam int DIGITS = 16;
  localparam int EXP_W  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, op_sub = 1'b0;
  logic a_sign = 1'b0, b_sign = 1'b0;
  logic [EXP_W-1:0] a_exp = '0, b_exp = '0;
  logic [4*DIGITS-1:0] a_sig = '0, b_sig = '0;
  logic out_valid, r_sign;
  logic [EXP_W-1:0] r_exp;
  logic [4*DIGITS-1:0] r_sig;

  always #2 clk = ~clk;

  dfp_addsub #(.DIGITS(DIGITS), .EXP_W(EXP_W)) uut (
    .clk, .rst, .in_valid, .op_sub, .a_sign, .a_exp, .a_sig,
    .b_sign, .b_exp, .b_sig, .out_valid, .r_sign, .r_exp, .r_sig
  );

  typedef struct {
    logic s;
    logic [EXP_W-1:0] e;
    logic [4*DIGITS-1:0] m;
    string tag;
  } item_t;
  item_t q[$];

  int checks = 0, failures = 0;
  bit done = 0;

  function automatic longint unsigned pow10(int n);
    longint unsigned p = 1;
    for (int i = 0; i < n; i++) p = p * 10;
    return p;
  endfunction

  function automatic logic [4*DIGITS-1:0] to_bcd(longint unsigned v);
    logic [4*DIGITS-1:0] o;
    for (int i = 0; i < DIGITS; i++) begin
      o[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return o;
  endfunction

  task automatic run(string tag, logic op, logic as, int ae, longint unsigned am,
                     logic bs, int be, longint unsigned bm);
    item_t it;
    logic bse, ls, eff;
    int le, se, d;
    longint unsigned lm, sm, sa, res;
    bse = bs ^ op;
    if (be > ae) begin ls = bse; le = be; lm = bm; se = ae; sm = am; end
    else         begin ls = as;  le = ae; lm = am; se = be; sm = bm; end
    d   = le - se;
    sa  = (d >= DIGITS + 1) ? 64'd0 : sm / pow10(d);
    eff = as ^ bse;
    it.s = ls;
    if (!eff) begin
      res = lm + sa;
      if (res >= pow10(DIGITS)) begin res = res / 10; le = le + 1; end
    end else if (lm >= sa) res = lm - sa;
    else begin res = sa - lm; it.s = ~ls; end
    it.e = EXP_W'(le);
    it.m = to_bcd(res);
    it.tag = tag;
    q.push_back(it);
    in_valid = 1'b1; op_sub = op;
    a_sign = as; a_exp = EXP_W'(ae); a_sig = to_bcd(am);
    b_sign = bs; b_exp = EXP_W'(be); b_sig = to_bcd(bm);
    @(negedge clk);
  endtask

  task automatic idle_check(string tag);
    in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL %s idle out_valid actual=%b expected=0", tag, out_valid);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (q.size() == 0) begin
        failures++;
        $display("FAIL R9 unexpected out_valid actual=1 expected=0");
      end else begin
        item_t e;
        e = q.pop_front();
        if (r_sign !== e.s || r_exp !== e.e || r_sig !== e.m) begin
          failures++;
          $display("FAIL %s actual=%b/%0d/%h expected=%b/%0d/%h",
                   e.tag, r_sign, r_exp, r_sig, e.s, e.e, e.m);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || r_sig !== '0 || r_exp !== '0 || r_sign !== 1'b0) begin
      failures++;
      $display("FAIL R9 reset actual=%b/%h expected=0/0", out_valid, r_sig);
    end
    rst = 1'b0;
    @(negedge clk);

    run("R5 digit carry", 0, 0, 398, 9, 0, 398, 1);
    run("R5 multi carry", 0, 0, 398, 64'd4999999, 0, 398, 64'd5000001);
    run("R1 sub request", 1, 0, 398, 5, 0, 398, 3);
    run("R1 sub of negative", 1, 0, 398, 5, 1, 398, 3);
    run("R1 mixed signs add", 0, 1, 398, 70, 0, 398, 20);
    idle_check("R9 gap");
    run("R2 A larger exp", 0, 0, 400, 64'd1000000000000000, 1, 398, 200);
    run("R2 R7 B larger exp", 0, 1, 398, 7000, 0, 401, 64'd5000000000000000);
    run("R7 B sign via op_sub", 1, 0, 398, 10, 0, 399, 50);
    run("R3 align truncate", 0, 0, 398, 987654321, 0, 402, 64'd1234567890123456);
    run("R8 borrow", 1, 0, 398, 3, 0, 398, 8);
    run("R8 borrow negative large", 1, 1, 100, 1234, 1, 100, 5678);
    run("R8 borrow after shift", 0, 0, 405, 12, 1, 403, 64'd99999);
    run("R7 exact zero", 1, 0, 398, 42, 0, 398, 42);
    run("R6 carry out", 0, 0, 398, 64'd9999999999999999, 0, 398, 1);
    run("R6 carry repeat", 0, 0, 500, 64'd5555555555555555, 0, 500, 64'd5555555555555555);
    run("R4 diff 17", 0, 0, 398, 64'd9999999999999999, 0, 415, 64'd1234567890123456);
    run("R4 diff 16", 0, 0, 414, 64'd1234567890123456, 0, 398, 64'd9999999999999999);
    run("R4 huge diff sub", 1, 0, 700, 64'd3000000000000000, 0, 2, 64'd9999999999999999);
    idle_check("R9 end idle");
    repeat (2) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R9 missing results actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule